// File: doc/BRIEF.md
# Interrupt Distributor State Tracker

This block holds the per-interrupt bookkeeping of a small multi-CPU interrupt controller. For each interrupt it keeps five per-CPU bitmasks: enabled, latched pending, active, sampled line level and group. Each interrupt also has a trigger-type flag, edge or level, and a one-of-N delivery flag. Priority is banked per CPU for the low internal interrupts and shared by all CPUs for the rest.

Inputs arrive from three sources. Interrupt lines are sampled on every clock. Software-style commands set or clear a state mask under a CPU mask, or change a per-interrupt flag. A CPU interface sends acknowledge-side clear-pending and clear-active requests. Status leaves through a combinational query port that is addressed by interrupt number and CPU. The block does not select the highest-priority interrupt, decode a register bus or model security.

Top module: `irq_dist_state`

## Requirements
- R1: After a synchronous active-low reset, every query output reads zero for every interrupt and CPU. This covers the enabled, pending, active and group bits, the trigger flag, the one-of-N flag and the priority.
- R2: The command ops have these encodings: 1/2 set/clear enable, 3/4 set/clear pending, 5/6 set/clear active, 7/8 set/clear group, 9/10 set/clear the edge-trigger flag, 11/12 set/clear the one-of-N flag. A mask op ORs `cmd_mask` into the addressed mask or clears the bits it names, so that CPUs outside the mask keep their bits. Flag ops ignore the mask.
- R3: An interrupt with its edge flag set latches pending for a CPU only at a clock where that CPU's line is high and was low at the previous clock. A line that stays high does not latch pending again after the bit is cleared.
- R4: When the edge flag is clear and the revision mode is normal, an interrupt reads as pending for a CPU if its latched bit is set or its sampled line is high. The line sample taken at a clock edge is visible right after that edge, and a level alone never sets the latched bit.
- R5: A clear-pending request or command clears only the latched bit. A level-triggered interrupt whose line is still high keeps reading as pending.
- R6: An acknowledge clear-pending clears the pending bit of every CPU when the interrupt's one-of-N flag is set. When the flag is clear, it clears only the bit of `ack_cpu`.
- R7: An acknowledge clear-active on an interrupt numbered below `NINT` (default 32) clears only the bit of `ack_cpu`. At or above `NINT` it clears the active bit of every CPU.
- R8: A priority write to an interrupt below `NINT` lands in the bank of `prio_cpu` and is read back only by that CPU. A write at or above `NINT` lands in one shared entry that every CPU reads, whatever `prio_cpu` was.
- R9: When a set source and a clear source hit the same bit in the same cycle, set wins. Set sources are a set command or a latched edge. Clear sources are a clear command or an acknowledge request.
- R10: With `LEGACY` = 1, the pending query returns the latched bit only and ignores the line level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| line_lvl | input | NIRQ*NCPU | Interrupt line levels, [irq][cpu] |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 4 | Command op (see R2) |
| cmd_irq | input | IRQ_W | Command interrupt number |
| cmd_mask | input | NCPU | Command CPU mask |
| ack_clr_pend | input | 1 | Acknowledge-side clear-pending |
| ack_clr_act | input | 1 | Acknowledge-side clear-active |
| ack_irq | input | IRQ_W | Acknowledge interrupt number |
| ack_cpu | input | CPU_W | Requesting CPU |
| prio_we | input | 1 | Priority write strobe |
| prio_irq | input | IRQ_W | Priority write interrupt |
| prio_cpu | input | CPU_W | Priority write CPU |
| prio_val | input | PRIO_W | Priority value |
| q_irq | input | IRQ_W | Query interrupt |
| q_cpu | input | CPU_W | Query CPU |
| q_enabled | output | 1 | Enabled bit |
| q_pending | output | 1 | Effective pending |
| q_active | output | 1 | Active bit |
| q_group | output | 1 | Group bit |
| q_edge | output | 1 | Edge-trigger flag |
| q_model | output | 1 | One-of-N flag |
| q_priority | output | PRIO_W | Priority seen by q_cpu |

## Verification
Some rules are checked by properties on every cycle. These are the zero state after reset, the all-CPU active clear for shared interrupts, the single-CPU active clear for internal ones, the all-CPU pending clear under the one-of-N flag, the level term of the pending query, and the latched-only reading in legacy mode. Other rules need the bench's scenarios, because they depend on history that a single property does not hold. These are edge detection against the previous sample and its one-shot nature, set winning over clear, the banked versus shared priority lookup, and the mask-limited effect of commands on other CPUs.

// File: rtl/irq_dist_pkg.sv
// Package: command encodings shared by the state tracker and its checker.
package irq_dist_pkg;
    typedef enum logic [3:0] {
        OP_NOP       = 4'd0,
        OP_SET_EN    = 4'd1,
        OP_CLR_EN    = 4'd2,
        OP_SET_PEND  = 4'd3,
        OP_CLR_PEND  = 4'd4,
        OP_SET_ACT   = 4'd5,
        OP_CLR_ACT   = 4'd6,
        OP_SET_GRP   = 4'd7,
        OP_CLR_GRP   = 4'd8,
        OP_SET_EDGE  = 4'd9,
        OP_CLR_EDGE  = 4'd10,
        OP_SET_MODEL = 4'd11,
        OP_CLR_MODEL = 4'd12
    } dist_op_e;
endpackage

// File: rtl/irq_line_sampler.sv
// Module: irq_line_sampler
// Registers every interrupt line on each clock and flags a rising edge
// by comparing the live input with the previous sample of that input.
// Assumes the lines are already synchronous to clk.
module irq_line_sampler #(
    parameter int NIRQ = 64,
    parameter int NCPU = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NIRQ-1:0][NCPU-1:0] line_lvl,
    output logic [NIRQ-1:0][NCPU-1:0] lvl_q,
    output logic [NIRQ-1:0][NCPU-1:0] rise
);
    // Sample register for all lines.
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= line_lvl;
    end

    // Rising edge: high now, low at the previous sample.
    always_comb rise = line_lvl & ~lvl_q;
endmodule

// File: rtl/irq_slot_state.sv
// Module: irq_slot_state
// State of one interrupt: per-CPU enabled, pending latch, active and group
// masks, plus the edge-trigger and one-of-N flags. Set sources take
// precedence over clear sources in the same cycle. SHARED selects
// whether an acknowledge clear-active hits all CPUs.
module irq_slot_state
    import irq_dist_pkg::*;
#(
    parameter int NCPU   = 4,
    parameter bit SHARED = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_hit,
    input  dist_op_e        op,
    input  logic [NCPU-1:0] mask,
    input  logic [NCPU-1:0] rise,
    input  logic            ack_pend_hit,
    input  logic            ack_act_hit,
    input  logic [NCPU-1:0] ack_oh,
    output logic [NCPU-1:0] en_q,
    output logic [NCPU-1:0] pend_q,
    output logic [NCPU-1:0] act_q,
    output logic [NCPU-1:0] grp_q,
    output logic            edge_q,
    output logic            model_q
);
    localparam logic [NCPU-1:0] ALL = {NCPU{1'b1}};

    logic [NCPU-1:0] en_s, en_c, pd_s, pd_c, ac_s, ac_c, gp_s, gp_c;
    logic [NCPU-1:0] pend_clr_scope, act_clr_scope;

    // Scope of acknowledge clears: one-of-N pending hits all, shared active hits all.
    always_comb begin
        pend_clr_scope = model_q ? ALL : ack_oh;
        act_clr_scope  = SHARED  ? ALL : ack_oh;
    end

    // Decode set and clear masks from command, edges and acknowledges.
    always_comb begin
        en_s = '0; en_c = '0; pd_s = '0; pd_c = '0;
        ac_s = '0; ac_c = '0; gp_s = '0; gp_c = '0;
        if (cmd_hit) begin
            unique case (op)
                OP_SET_EN:   en_s = mask;
                OP_CLR_EN:   en_c = mask;
                OP_SET_PEND: pd_s = mask;
                OP_CLR_PEND: pd_c = mask;
                OP_SET_ACT:  ac_s = mask;
                OP_CLR_ACT:  ac_c = mask;
                OP_SET_GRP:  gp_s = mask;
                OP_CLR_GRP:  gp_c = mask;
                default: ;
            endcase
        end
        if (edge_q)       pd_s = pd_s | rise;
        if (ack_pend_hit) pd_c = pd_c | pend_clr_scope;
        if (ack_act_hit)  ac_c = ac_c | act_clr_scope;
    end

    // Mask registers: clear first, then set so that set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q   <= '0;
            pend_q <= '0;
            act_q  <= '0;
            grp_q  <= '0;
        end else begin
            en_q   <= (en_q   & ~en_c) | en_s;
            pend_q <= (pend_q & ~pd_c) | pd_s;
            act_q  <= (act_q  & ~ac_c) | ac_s;
            grp_q  <= (grp_q  & ~gp_c) | gp_s;
        end
    end

    // Per-interrupt flags, written by flag commands only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_q  <= 1'b0;
            model_q <= 1'b0;
        end else if (cmd_hit) begin
            if (op == OP_SET_EDGE)  edge_q  <= 1'b1;
            if (op == OP_CLR_EDGE)  edge_q  <= 1'b0;
            if (op == OP_SET_MODEL) model_q <= 1'b1;
            if (op == OP_CLR_MODEL) model_q <= 1'b0;
        end
    end
endmodule

// File: rtl/irq_prio_store.sv
// Module: irq_prio_store
// Priority storage: a bank per CPU for interrupts below NINT and one
// shared entry for each interrupt at or above NINT. Combinational read.
// Assumes NIRQ > NINT.
module irq_prio_store #(
    parameter int NIRQ   = 64,
    parameter int NCPU   = 4,
    parameter int NINT   = 32,
    parameter int PRIO_W = 8,
    localparam int IRQ_W = $clog2(NIRQ),
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1,
    localparam int NSHR  = NIRQ - NINT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IRQ_W-1:0]  wr_irq,
    input  logic [CPU_W-1:0]  wr_cpu,
    input  logic [PRIO_W-1:0] wr_val,
    input  logic [IRQ_W-1:0]  rd_irq,
    input  logic [CPU_W-1:0]  rd_cpu,
    output logic [PRIO_W-1:0] rd_val
);
    logic [PRIO_W-1:0] bank [NCPU][NINT];
    logic [PRIO_W-1:0] shr  [NSHR];

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        for (genvar i = 0; i < NINT; i++) begin : g_int
            // Banked entry for one CPU and one internal interrupt.
            always_ff @(posedge clk) begin
                if (!rst_n) bank[c][i] <= '0;
                else if (we && wr_irq == IRQ_W'(i) && wr_cpu == CPU_W'(c))
                    bank[c][i] <= wr_val;
            end
        end
    end

    for (genvar j = 0; j < NSHR; j++) begin : g_shr
        // Shared entry for one interrupt at or above NINT.
        always_ff @(posedge clk) begin
            if (!rst_n) shr[j] <= '0;
            else if (we && wr_irq == IRQ_W'(NINT + j)) shr[j] <= wr_val;
        end
    end

    // Read mux: banked below NINT, shared otherwise.
    always_comb begin
        rd_val = '0;
        for (int c = 0; c < NCPU; c++)
            for (int i = 0; i < NINT; i++)
                if (rd_irq == IRQ_W'(i) && rd_cpu == CPU_W'(c)) rd_val = bank[c][i];
        for (int j = 0; j < NSHR; j++)
            if (rd_irq == IRQ_W'(NINT + j)) rd_val = shr[j];
    end
endmodule

// File: rtl/irq_dist_state.sv
// Module: irq_dist_state (top)
// Per-interrupt state tracker for a multi-CPU interrupt controller.
// Samples lines, applies commands and acknowledge clears, stores priority
// and answers combinational queries. LEGACY=1 makes the pending query
// ignore line levels. Assumes one command and one acknowledge per cycle.
module irq_dist_state
    import irq_dist_pkg::*;
#(
    parameter int NIRQ   = 64,
    parameter int NCPU   = 4,
    parameter int NINT   = 32,
    parameter int PRIO_W = 8,
    parameter bit LEGACY = 1'b0,
    localparam int IRQ_W = $clog2(NIRQ),
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NIRQ-1:0][NCPU-1:0] line_lvl,
    input  logic                      cmd_valid,
    input  logic [3:0]                cmd_op,
    input  logic [IRQ_W-1:0]          cmd_irq,
    input  logic [NCPU-1:0]           cmd_mask,
    input  logic                      ack_clr_pend,
    input  logic                      ack_clr_act,
    input  logic [IRQ_W-1:0]          ack_irq,
    input  logic [CPU_W-1:0]          ack_cpu,
    input  logic                      prio_we,
    input  logic [IRQ_W-1:0]          prio_irq,
    input  logic [CPU_W-1:0]          prio_cpu,
    input  logic [PRIO_W-1:0]         prio_val,
    input  logic [IRQ_W-1:0]          q_irq,
    input  logic [CPU_W-1:0]          q_cpu,
    output logic                      q_enabled,
    output logic                      q_pending,
    output logic                      q_active,
    output logic                      q_group,
    output logic                      q_edge,
    output logic                      q_model,
    output logic [PRIO_W-1:0]         q_priority
);
    logic [NIRQ-1:0][NCPU-1:0] lvl_q, rise;
    logic [NIRQ-1:0][NCPU-1:0] en_q, pend_q, act_q, grp_q;
    logic [NIRQ-1:0]           edge_q, model_q;
    logic [NCPU-1:0]           ack_oh;
    dist_op_e                  op;

    // Decode the command op and the requesting CPU.
    always_comb begin
        op     = dist_op_e'(cmd_op);
        ack_oh = NCPU'(1) << ack_cpu;
    end

    irq_line_sampler #(.NIRQ(NIRQ), .NCPU(NCPU)) i_sampler (
        .clk(clk), .rst_n(rst_n), .line_lvl(line_lvl),
        .lvl_q(lvl_q), .rise(rise)
    );

    for (genvar i = 0; i < NIRQ; i++) begin : g_slot
        irq_slot_state #(.NCPU(NCPU), .SHARED(i >= NINT)) i_slot (
            .clk(clk), .rst_n(rst_n),
            .cmd_hit(cmd_valid && cmd_irq == IRQ_W'(i)),
            .op(op), .mask(cmd_mask), .rise(rise[i]),
            .ack_pend_hit(ack_clr_pend && ack_irq == IRQ_W'(i)),
            .ack_act_hit(ack_clr_act && ack_irq == IRQ_W'(i)),
            .ack_oh(ack_oh),
            .en_q(en_q[i]), .pend_q(pend_q[i]), .act_q(act_q[i]),
            .grp_q(grp_q[i]), .edge_q(edge_q[i]), .model_q(model_q[i])
        );
    end

    irq_prio_store #(.NIRQ(NIRQ), .NCPU(NCPU), .NINT(NINT), .PRIO_W(PRIO_W)) i_prio (
        .clk(clk), .rst_n(rst_n), .we(prio_we), .wr_irq(prio_irq),
        .wr_cpu(prio_cpu), .wr_val(prio_val), .rd_irq(q_irq),
        .rd_cpu(q_cpu), .rd_val(q_priority)
    );

    // Query outputs; pending adds the line level for level interrupts.
    always_comb begin
        q_enabled = en_q[q_irq][q_cpu];
        q_active  = act_q[q_irq][q_cpu];
        q_group   = grp_q[q_irq][q_cpu];
        q_edge    = edge_q[q_irq];
        q_model   = model_q[q_irq];
        if (LEGACY) q_pending = pend_q[q_irq][q_cpu];
        else        q_pending = pend_q[q_irq][q_cpu] |
                                (~edge_q[q_irq] & lvl_q[q_irq][q_cpu]);
    end
endmodule

// File: rtl/irq_dist_state_chk.sv
// Module: irq_dist_state_chk
// Property checker bound into irq_dist_state; observes ports and state.
module irq_dist_state_chk
    import irq_dist_pkg::*;
#(
    parameter int NIRQ   = 64,
    parameter int NCPU   = 4,
    parameter int NINT   = 32,
    parameter bit LEGACY = 1'b0,
    localparam int IRQ_W = $clog2(NIRQ),
    localparam int CPU_W = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cmd_valid,
    input logic [IRQ_W-1:0]          ack_irq,
    input logic [CPU_W-1:0]          ack_cpu,
    input logic                      ack_clr_pend,
    input logic                      ack_clr_act,
    input logic [IRQ_W-1:0]          q_irq,
    input logic [CPU_W-1:0]          q_cpu,
    input logic                      q_pending,
    input logic [NIRQ-1:0][NCPU-1:0] en_q,
    input logic [NIRQ-1:0][NCPU-1:0] pend_q,
    input logic [NIRQ-1:0][NCPU-1:0] act_q,
    input logic [NIRQ-1:0][NCPU-1:0] grp_q,
    input logic [NIRQ-1:0][NCPU-1:0] lvl_q,
    input logic [NIRQ-1:0]           edge_q,
    input logic [NIRQ-1:0]           model_q
);
    logic rst_d;

    // Remembers that reset was asserted at the previous edge.
    always_ff @(posedge clk) rst_d <= !rst_n;

    // State cleared by reset.
    always_ff @(posedge clk) begin
        if (rst_d)
            AST_RESET_ZERO: assert (en_q == '0 && pend_q == '0 && act_q == '0 &&
                                    grp_q == '0 && edge_q == '0 && model_q == '0); // R1
    end

    AST_SHARED_ACT_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr_act && !cmd_valid && ack_irq >= IRQ_W'(NINT))
        |=> act_q[$past(ack_irq)] == '0); // R7

    AST_INT_ACT_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr_act && !cmd_valid && ack_irq < IRQ_W'(NINT))
        |=> !act_q[$past(ack_irq)][$past(ack_cpu)]); // R7

    AST_MODEL_PEND_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_clr_pend && !cmd_valid && model_q[ack_irq] && !edge_q[ack_irq])
        |=> pend_q[$past(ack_irq)] == '0); // R6

    AST_LEVEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        (!LEGACY && !edge_q[q_irq] && lvl_q[q_irq][q_cpu]) |-> q_pending); // R4

    AST_LEGACY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        LEGACY |-> (q_pending == pend_q[q_irq][q_cpu])); // R10
endmodule

bind irq_dist_state irq_dist_state_chk #(
    .NIRQ(NIRQ), .NCPU(NCPU), .NINT(NINT), .LEGACY(LEGACY)
) i_chk (.*);

// File: tb/test_irq_dist_state.sv
`timescale 1ns/1ps
module test_irq_dist_state;
    localparam int NIRQ = 64, NCPU = 4, NINT = 32, PW = 8;
    localparam int IW = 6, CW = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [NIRQ-1:0][NCPU-1:0] line = '0;
    logic cmd_valid = 0; logic [3:0] cmd_op = 0; logic [IW-1:0] cmd_irq = 0;
    logic [NCPU-1:0] cmd_mask = 0;
    logic ack_p = 0, ack_a = 0; logic [IW-1:0] ack_irq = 0; logic [CW-1:0] ack_cpu = 0;
    logic p_we = 0; logic [IW-1:0] p_irq = 0; logic [CW-1:0] p_cpu = 0; logic [PW-1:0] p_val = 0;
    logic [IW-1:0] q_irq = 0; logic [CW-1:0] q_cpu = 0;
    logic o_en, o_pd, o_ac, o_gp, o_ed, o_md, l_pd, l_en, l_ac, l_gp, l_ed, l_md;
    logic [PW-1:0] o_pr, l_pr;

    int n_cmp = 0, n_bad = 0;
    bit done = 0;

    // Bench model of the state, built from the requirements.
    bit m_en[NIRQ][NCPU], m_pd[NIRQ][NCPU], m_ac[NIRQ][NCPU], m_gp[NIRQ][NCPU];
    bit m_lv[NIRQ][NCPU], m_ed[NIRQ], m_md[NIRQ];
    logic [PW-1:0] m_bank[NCPU][NINT], m_shr[NIRQ-NINT];

    always #4 clk = ~clk;

    irq_dist_state #(.NIRQ(NIRQ), .NCPU(NCPU), .NINT(NINT), .PRIO_W(PW)) i_irq_dist_state (
        .clk(clk), .rst_n(rst_n), .line_lvl(line), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_irq(cmd_irq), .cmd_mask(cmd_mask), .ack_clr_pend(ack_p), .ack_clr_act(ack_a),
        .ack_irq(ack_irq), .ack_cpu(ack_cpu), .prio_we(p_we), .prio_irq(p_irq),
        .prio_cpu(p_cpu), .prio_val(p_val), .q_irq(q_irq), .q_cpu(q_cpu),
        .q_enabled(o_en), .q_pending(o_pd), .q_active(o_ac), .q_group(o_gp),
        .q_edge(o_ed), .q_model(o_md), .q_priority(o_pr));

    irq_dist_state #(.NIRQ(NIRQ), .NCPU(NCPU), .NINT(NINT), .PRIO_W(PW), .LEGACY(1'b1)) i_irq_dist_state_legacy (
        .clk(clk), .rst_n(rst_n), .line_lvl(line), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_irq(cmd_irq), .cmd_mask(cmd_mask), .ack_clr_pend(ack_p), .ack_clr_act(ack_a),
        .ack_irq(ack_irq), .ack_cpu(ack_cpu), .prio_we(p_we), .prio_irq(p_irq),
        .prio_cpu(p_cpu), .prio_val(p_val), .q_irq(q_irq), .q_cpu(q_cpu),
        .q_enabled(l_en), .q_pending(l_pd), .q_active(l_ac), .q_group(l_gp),
        .q_edge(l_ed), .q_model(l_md), .q_priority(l_pr));

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // Expected pending from the model (R4, R10).
    function automatic bit exp_pend(int i, int c, bit legacy);
        return legacy ? m_pd[i][c] : (m_pd[i][c] | (!m_ed[i] & m_lv[i][c]));
    endfunction

    function automatic logic [PW-1:0] exp_prio(int i, int c);
        return (i < NINT) ? m_bank[c][i] : m_shr[i-NINT];
    endfunction

    // Model update for one clock edge, using the inputs now driven (R2, R3, R6, R7, R9).
    task automatic model_edge();
        bit hit, sp, cp, sa, ca;
        for (int i = 0; i < NIRQ; i++) begin
            hit = cmd_valid && cmd_irq == i;
            for (int c = 0; c < NCPU; c++) begin
                sp = (hit && cmd_op == 3 && cmd_mask[c]) || (m_ed[i] && line[i][c] && !m_lv[i][c]);
                cp = (hit && cmd_op == 4 && cmd_mask[c]) || (ack_p && ack_irq == i && (m_md[i] || c == ack_cpu));
                sa = hit && cmd_op == 5 && cmd_mask[c];
                ca = (hit && cmd_op == 6 && cmd_mask[c]) || (ack_a && ack_irq == i && (i >= NINT || c == ack_cpu));
                m_pd[i][c] = sp | (m_pd[i][c] & !cp);
                m_ac[i][c] = sa | (m_ac[i][c] & !ca);
                if (hit && cmd_op == 1 && cmd_mask[c]) m_en[i][c] = 1;
                if (hit && cmd_op == 2 && cmd_mask[c]) m_en[i][c] = 0;
                if (hit && cmd_op == 7 && cmd_mask[c]) m_gp[i][c] = 1;
                if (hit && cmd_op == 8 && cmd_mask[c]) m_gp[i][c] = 0;
                m_lv[i][c] = line[i][c];
            end
            if (hit && cmd_op == 9)  m_ed[i] = 1;
            if (hit && cmd_op == 10) m_ed[i] = 0;
            if (hit && cmd_op == 11) m_md[i] = 1;
            if (hit && cmd_op == 12) m_md[i] = 0;
        end
        if (p_we) begin
            if (p_irq < NINT) m_bank[p_cpu][p_irq] = p_val;
            else              m_shr[p_irq-NINT] = p_val;
        end
    endtask

    // One clock: inputs held from the preceding negedge, strobes dropped after.
    task automatic step();
        model_edge();
        @(posedge clk); #1;
        cmd_valid = 0; ack_p = 0; ack_a = 0; p_we = 0;
        @(negedge clk);
    endtask

    task automatic cmd(input int op, input int irq, input logic [3:0] m);
        cmd_valid = 1; cmd_op = 4'(op); cmd_irq = IW'(irq); cmd_mask = m;
    endtask

    task automatic query(input int irq, input int cpu);
        q_irq = IW'(irq); q_cpu = CW'(cpu); #1;
    endtask

    // Pending mask across all CPUs from the normal instance.
    task automatic pend_mask(input int irq, output logic [3:0] m);
        for (int c = 0; c < NCPU; c++) begin query(irq, c); m[c] = o_pd; end
    endtask

    task automatic act_mask(input int irq, output logic [3:0] m);
        for (int c = 0; c < NCPU; c++) begin query(irq, c); m[c] = o_ac; end
    endtask

    task automatic full_check(input int i, input int c);
        query(i, c);
        chk("R2 R4 R8 state", {o_en, o_pd, o_ac, o_gp, o_ed, o_md, o_pr},
            {m_en[i][c], exp_pend(i, c, 0), m_ac[i][c], m_gp[i][c], m_ed[i], m_md[i], exp_prio(i, c)});
        chk("R10 legacy pending", l_pd, exp_pend(i, c, 1));
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    initial begin
        logic [3:0] m;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NIRQ; i++) begin
            m_ed[i] = 0; m_md[i] = 0;
            for (int c = 0; c < NCPU; c++) begin
                m_en[i][c] = 0; m_pd[i][c] = 0; m_ac[i][c] = 0; m_gp[i][c] = 0; m_lv[i][c] = 0;
            end
        end
        for (int c = 0; c < NCPU; c++) for (int i = 0; i < NINT; i++) m_bank[c][i] = 0;
        for (int j = 0; j < NIRQ - NINT; j++) m_shr[j] = 0;

        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        // R1: everything zero after reset.
        for (int k = 0; k < 8; k++) begin
            query(k * 9, k % 4);
            chk("R1 reset", {o_en, o_pd, o_ac, o_gp, o_ed, o_md, o_pr}, '0);
        end

        // R2: mask-limited set and clear.
        cmd(1, 10, 4'b0101); step();
        cmd(2, 10, 4'b0100); step();
        for (int c = 0; c < NCPU; c++) begin query(10, c); chk("R2 enable mask", o_en, (c == 0)); end

        // R3: edge interrupt latches once per rising edge.
        cmd(9, 3, 0); step();
        line[3] = 4'b0010; step();
        pend_mask(3, m); chk("R3 rise latches", m, 4'b0010);
        ack_p = 1; ack_irq = 3; ack_cpu = 1; step();
        pend_mask(3, m); chk("R3 steady high no relatch", m, 4'b0000);
        line[3] = 4'b0000; step();
        line[3] = 4'b0010; step();
        pend_mask(3, m); chk("R3 second rise", m, 4'b0010);

        // R4: level visible right after the sampling edge, not latched.
        line[40] = 4'b1000; step();
        pend_mask(40, m); chk("R4 level pending", m, 4'b1000);
        query(40, 3); chk("R10 legacy ignores level", l_pd, 0);
        line[40] = 4'b0000; step();
        pend_mask(40, m); chk("R4 level not latched", m, 4'b0000);

        // R5: clear-pending leaves a high level pending.
        cmd(3, 41, 4'b0001); line[41] = 4'b0001; step();
        ack_p = 1; ack_irq = 41; ack_cpu = 0; step();
        pend_mask(41, m); chk("R5 level keeps pending", m, 4'b0001);
        line[41] = 4'b0000; step();
        pend_mask(41, m); chk("R5 latch cleared", m, 4'b0000);

        // R6: one-of-N clears all CPUs, otherwise only the requester.
        cmd(11, 50, 0); step();
        cmd(3, 50, 4'b1111); step();
        ack_p = 1; ack_irq = 50; ack_cpu = 2; step();
        pend_mask(50, m); chk("R6 one-of-N clears all", m, 4'b0000);
        cmd(3, 51, 4'b1111); step();
        ack_p = 1; ack_irq = 51; ack_cpu = 2; step();
        pend_mask(51, m); chk("R6 normal clears requester", m, 4'b1011);

        // R7: internal vs shared active clear.
        cmd(5, 20, 4'b1111); step();
        ack_a = 1; ack_irq = 20; ack_cpu = 1; step();
        act_mask(20, m); chk("R7 internal clears one", m, 4'b1101);
        cmd(5, 45, 4'b1111); step();
        ack_a = 1; ack_irq = 45; ack_cpu = 1; step();
        act_mask(45, m); chk("R7 shared clears all", m, 4'b0000);

        // R8: banked and shared priority.
        p_we = 1; p_irq = 5; p_cpu = 0; p_val = 8'h11; step();
        p_we = 1; p_irq = 5; p_cpu = 1; p_val = 8'h22; step();
        p_we = 1; p_irq = 40; p_cpu = 0; p_val = 8'h33; step();
        query(5, 0); chk("R8 bank cpu0", o_pr, 8'h11);
        query(5, 1); chk("R8 bank cpu1", o_pr, 8'h22);
        query(5, 2); chk("R8 bank cpu2 untouched", o_pr, 8'h00);
        query(40, 3); chk("R8 shared seen by cpu3", o_pr, 8'h33);

        // R9: set wins over same-cycle clear.
        line[3] = 4'b0000; step();
        line[3] = 4'b0100; ack_p = 1; ack_irq = 3; ack_cpu = 2; step();
        pend_mask(3, m); chk("R9 edge beats ack clear", m[2], 1);
        cmd(3, 52, 4'b0001); ack_p = 1; ack_irq = 52; ack_cpu = 0; step();
        pend_mask(52, m); chk("R9 set cmd beats ack clear", m, 4'b0001);

        // Random traffic against the model.
        for (int n = 0; n < 400; n++) begin
            int pick[8] = '{0, 1, 15, 16, 31, 32, 33, 63};
            int irq = ($urandom % 2) ? pick[$urandom % 8] : int'($urandom % NIRQ);
            if ($urandom % 4 != 0) cmd(1 + $urandom % 12, irq, 4'($urandom));
            if ($urandom % 3 == 0) begin
                ack_p = $urandom % 2; ack_a = $urandom % 2;
                ack_irq = IW'(($urandom % 2) ? irq : $urandom % NIRQ); ack_cpu = CW'($urandom);
            end
            if ($urandom % 5 == 0) begin
                p_we = 1; p_irq = IW'($urandom % NIRQ); p_cpu = CW'($urandom); p_val = PW'($urandom);
            end
            for (int k = 0; k < 3; k++) begin
                int li = ($urandom % 2) ? irq : int'($urandom % NIRQ);
                int lc = int'($urandom % NCPU);
                line[li][lc] = ~line[li][lc];
            end
            step();
            full_check(irq, int'($urandom % NCPU));
            full_check(int'($urandom % NIRQ), int'($urandom % NCPU));
        end
        summary();
    end
endmodule